// File: doc/BRIEF.md
# Low-Power Seconds Counter

The block keeps wall-clock time as a 47-bit binary count that advances once per edge of a slow, low-power clock (nominally 32768 Hz). Read as fixed point, the top 32 bits are whole seconds and the bottom 15 bits are fractions of a second. A 32-bit register bus running on an unrelated system clock reads and writes the count, along with a control word that holds a run request and a calibration setting.

The bus and counter clocks have no phase relation. The run request reaches the counter through a two-flop synchroniser, and the state the counter actually reached is synchronised back to the bus side. Software writes the run bit, then polls the read-back bit until it matches. A count write is carried across by a toggle request/acknowledge handshake. The counter takes it only while it is stopped.

The count is read live across the clock boundary and is split over two registers, so a single pair of reads can be torn. Software reads upper, lower, upper, lower and repeats until both assembled values agree. Calibration applies a signed correction once per calibration period. The period is a parameter: a power-of-two number of ticks, with a default of 32768.

Top module: `lp_seconds_counter`

## Requirements
- R1: After reset, the control word, the upper count word and the lower count word all read zero.
- R2: The control word is at offset 0x38. Bits 14:10 hold a 5-bit calibration value and bit 8 a calibration-on flag; both read back as written. Every other control bit except bit 0 reads zero.
- R3: Control bit 0 is the run request when written. When read, it reports whether the counter is actually running. The read-back bit follows the written value only after synchronisation delay, and reads 0 while stopped.
- R4: When control bit 0 first reads back 1, the count still equals the value loaded before the run request. The first increment happens on the second slow-clock edge after the request leaves the slow-side synchroniser.
- R5: While running with calibration off, the count grows by exactly one on every slow-clock edge.
- R6: The upper word at offset 0x54-4 = 0x50 carries count bits 46:32 in its bits 14:0, with bits 31:15 zero. The lower word at 0x54 carries count bits 31:0. A carry from the lower word propagates into the upper word, and the count wraps from all ones to zero.
- R7: A write to either count word while the counter is running, or about to run, leaves the count unchanged.
- R8: A write to one count word while the counter is stopped replaces that word and leaves the other word unchanged.
- R9: With calibration on, the tick that completes each calibration period advances the count by 1 plus the calibration value, read as a 5-bit two's complement number (-16 to +15). All other ticks add one.
- R10: With calibration off, the calibration value has no effect on the count.
- R11: After control bit 0 reads back 0, the count holds still across slow-clock edges.
- R12: Bus addresses other than 0x38, 0x50 and 0x54 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| slowClk | input | 1 | Low-power counting clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWrEn | input | 1 | Write strobe, one bus cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The bench builds the block with the default 47-bit count but shortens the calibration period to 16 ticks, so a positive, a negative and a minimum-value correction each land within a few slow-clock cycles. The slow clock runs at about one eighth of the bus rate with an odd half period, which keeps the two clocks drifting against each other. It also leaves room to see the stopped count at the moment the read-back bit rises, before the first increment. Counts loaded just below a word boundary and just below the top of the 47-bit range exercise the carry into the upper word and the wrap to zero in a handful of ticks.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int CAL_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_UPPER = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_LOWER = 8'h54;

  localparam int BIT_RUN   = 0;
  localparam int BIT_CALON = 8;
  localparam int CAL_LSB   = 10;

  // Strobes and settings handed from the bus side to the slow side.
  typedef struct packed {
    logic             runReq;
    logic             calOn;
    logic [CAL_W-1:0] calVal;
    logic             wrToggle;
    logic             wrUpper;
    logic [BUS_W-1:0] wrWord;
  } strobes_t;
endpackage

// File: rtl/lpsc_bus_regs.sv
module lpsc_bus_regs
  import lpsc_pkg::*;
#(
  parameter int CNT_W = 47
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output strobes_t          stb,
  input  logic              runningSlow,
  input  logic              ackToggle,
  input  logic [CNT_W-1:0]  countSlow
);
  localparam int UP_W = CNT_W - BUS_W;

  logic runReq, calOn, wrToggle, wrUpper;
  logic [CAL_W-1:0] calVal;
  logic [BUS_W-1:0] wrWord;
  logic ackS1, ackS2, runS1, runS2;
  logic busy, hitCount;

  assign busy     = wrToggle ^ ackS2;
  assign hitCount = busWrEn && (busAddr == OFS_UPPER || busAddr == OFS_LOWER);

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      runReq   <= 1'b0;
      calOn    <= 1'b0;
      calVal   <= '0;
      wrToggle <= 1'b0;
      wrUpper  <= 1'b0;
      wrWord   <= '0;
      ackS1    <= 1'b0;
      ackS2    <= 1'b0;
      runS1    <= 1'b0;
      runS2    <= 1'b0;
    end else begin
      ackS1 <= ackToggle;
      ackS2 <= ackS1;
      runS1 <= runningSlow;
      runS2 <= runS1;
      if (busWrEn && busAddr == OFS_CTRL) begin
        runReq <= busWrData[BIT_RUN];
        calOn  <= busWrData[BIT_CALON];
        calVal <= busWrData[CAL_LSB +: CAL_W];
      end
      // A count write is launched only when no earlier one is in flight.
      if (hitCount && !busy) begin
        wrWord   <= busWrData;
        wrUpper  <= (busAddr == OFS_UPPER);
        wrToggle <= ~wrToggle;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_CTRL: begin
        busRdData[BIT_RUN]               = runS2;
        busRdData[BIT_CALON]             = calOn;
        busRdData[CAL_LSB +: CAL_W]      = calVal;
      end
      OFS_UPPER: busRdData[UP_W-1:0] = countSlow[CNT_W-1:BUS_W];
      OFS_LOWER: busRdData           = countSlow[BUS_W-1:0];
      default:   busRdData           = '0;
    endcase
  end

  always_comb begin
    stb.runReq   = runReq;
    stb.calOn    = calOn;
    stb.calVal   = calVal;
    stb.wrToggle = wrToggle;
    stb.wrUpper  = wrUpper;
    stb.wrWord   = wrWord;
  end
endmodule

// File: rtl/lpsc_tick_path.sv
module lpsc_tick_path
  import lpsc_pkg::*;
#(
  parameter int CNT_W    = 47,
  parameter int CAL_LOG2 = 15
) (
  input  logic             slowClk,
  input  logic             rstN,
  input  strobes_t         stb,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             runSettled,
  output logic             ackToggle,
  output logic             loadPulse
);
  localparam int UP_W = CNT_W - BUS_W;

  logic runS1;
  logic rq1, rq2, rq3;
  logic [CAL_LOG2-1:0] periodCnt;
  logic periodWrap, loadOk;
  logic [CNT_W-1:0] step;

  assign loadPulse  = rq2 ^ rq3;
  assign loadOk     = loadPulse && !(runSettled || running);
  assign periodWrap = &periodCnt;

  always_comb begin
    step = CNT_W'(1);
    if (stb.calOn && periodWrap)
      step = CNT_W'(1) + {{(CNT_W-CAL_W){stb.calVal[CAL_W-1]}}, stb.calVal};
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      runS1      <= 1'b0;
      runSettled <= 1'b0;
      running    <= 1'b0;
      rq1        <= 1'b0;
      rq2        <= 1'b0;
      rq3        <= 1'b0;
      ackToggle  <= 1'b0;
      periodCnt  <= '0;
      count      <= '0;
    end else begin
      runS1      <= stb.runReq;
      runSettled <= runS1;
      running    <= runSettled;
      rq1        <= stb.wrToggle;
      rq2        <= rq1;
      rq3        <= rq2;
      ackToggle  <= rq2;
      periodCnt  <= running ? periodCnt + 1'b1 : '0;
      if (loadOk) begin
        if (stb.wrUpper) count <= {stb.wrWord[UP_W-1:0], count[BUS_W-1:0]};
        else             count <= {count[CNT_W-1:BUS_W], stb.wrWord};
      end else if (running) begin
        count <= count + step;
      end
    end
  end
endmodule

// File: rtl/lp_seconds_counter.sv
module lp_seconds_counter
  import lpsc_pkg::*;
#(
  parameter int CNT_W    = 47,
  parameter int CAL_LOG2 = 15
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData
);
  strobes_t         stb;
  logic [CNT_W-1:0] count;
  logic             running, runSettled, ackToggle, loadPulse;

  lpsc_bus_regs #(.CNT_W(CNT_W)) u_regs (
    .busClk(busClk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .stb(stb),
    .runningSlow(running), .ackToggle(ackToggle), .countSlow(count)
  );

  lpsc_tick_path #(.CNT_W(CNT_W), .CAL_LOG2(CAL_LOG2)) u_tick (
    .slowClk(slowClk), .rstN(rstN), .stb(stb), .count(count),
    .running(running), .runSettled(runSettled), .ackToggle(ackToggle),
    .loadPulse(loadPulse)
  );
endmodule

// File: rtl/lpsc_checker.sv
module lpsc_checker
  import lpsc_pkg::*;
#(
  parameter int CNT_W = 47
) (
  input logic              busClk,
  input logic              slowClk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busRdData,
  input logic [CNT_W-1:0]  count,
  input logic              running,
  input logic              runSettled,
  input logic              loadPulse,
  input logic              calOn
);
  localparam int UP_W = CNT_W - BUS_W;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge slowClk) disable iff (!rstN)
    (!running && !loadPulse) |=> $stable(count)); // R11

  AST_PLAIN_STEP: assert property (@(posedge slowClk) disable iff (!rstN)
    (running && !calOn) |=> (count == $past(count) + CNT_W'(1))); // R5

  AST_NO_LOAD_ARMED: assert property (@(posedge slowClk) disable iff (!rstN)
    (runSettled && loadPulse && !running) |=> $stable(count)); // R7

  AST_START_GAP: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(runSettled) |=> $stable(count)); // R4

  AST_UPPER_ZERO_FILL: assert property (@(posedge busClk) disable iff (!rstN)
    (busAddr == OFS_UPPER) |-> (busRdData[BUS_W-1:UP_W] == '0)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge busClk) disable iff (!rstN)
    (busAddr != OFS_CTRL && busAddr != OFS_UPPER && busAddr != OFS_LOWER)
      |-> (busRdData == '0)); // R12
endmodule

bind lp_seconds_counter lpsc_checker #(.CNT_W(CNT_W)) u_chk (
  .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .busAddr(busAddr),
  .busRdData(busRdData), .count(count), .running(running),
  .runSettled(runSettled), .loadPulse(loadPulse), .calOn(stb.calOn)
);

// File: tb/test_lp_seconds_counter.sv
module test_lp_seconds_counter;
  import lpsc_pkg::*;

  logic busClk = 0, slowClk = 0, rstN = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 0;
  logic [BUS_W-1:0] busWrData = '0;
  logic [BUS_W-1:0] busRdData;
  int nChecks = 0, nFails = 0;

  always #10 busClk = ~busClk;   // 50 MHz
  always #83 slowClk = ~slowClk; // unrelated slow clock

  lp_seconds_counter #(.CNT_W(47), .CAL_LOG2(4)) i_lp_seconds_counter (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  typedef struct packed {
    logic [15:0] up;
    logic [31:0] lo;
    logic        calOn;
    logic [4:0]  cal;
    logic [7:0]  ticks;
    logic [15:0] expUp;
    logic [31:0] expLo;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{16'h0000, 32'h0000_0100, 1'b0, 5'd0,  8'd5,  16'h0000, 32'h0000_0105}, // R5
    '{16'h0001, 32'hFFFF_FFFD, 1'b0, 5'd0,  8'd4,  16'h0002, 32'h0000_0001}, // R6 carry
    '{16'h7FFF, 32'hFFFF_FFFE, 1'b0, 5'd0,  8'd3,  16'h0000, 32'h0000_0001}, // R6 wrap
    '{16'h0000, 32'h0000_0000, 1'b1, 5'h03, 8'd16, 16'h0000, 32'h0000_0013}, // R9 +3
    '{16'h0000, 32'h0000_1000, 1'b1, 5'h1E, 8'd20, 16'h0000, 32'h0000_1012}, // R9 -2
    '{16'h0000, 32'h0000_0050, 1'b0, 5'h07, 8'd16, 16'h0000, 32'h0000_0060}, // R10
    '{16'h0000, 32'h0000_0040, 1'b1, 5'h10, 8'd16, 16'h0000, 32'h0000_0040}  // R9 -16
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge busClk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge busClk);
    busWrEn = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  // Consistent double read of the split count.
  task automatic readCount(output logic [63:0] v);
    logic [31:0] u1, l1, u2, l2;
    for (int k = 0; k < 8; k++) begin
      busRead(OFS_UPPER, u1); busRead(OFS_LOWER, l1);
      busRead(OFS_UPPER, u2); busRead(OFS_LOWER, l2);
      if (u1 == u2 && l1 == l2) break;
    end
    v = {u2, l2};
  endtask

  task automatic waitStatus(input logic want);
    logic [31:0] d;
    for (int k = 0; k < 400; k++) begin
      @(negedge busClk);
      busRead(OFS_CTRL, d);
      if (d[0] == want) break;
    end
    check("R3 status read-back", {63'd0, d[0]}, {63'd0, want});
  endtask

  task automatic settle();
    repeat (60) @(negedge busClk);
  endtask

  initial begin : watchdog
    #(3_000_000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] c0, c1;
    repeat (5) @(negedge busClk);
    rstN = 1;
    repeat (3) @(negedge busClk);

    // R1 reset state
    busRead(OFS_CTRL, d);  check("R1 ctrl", {32'd0, d}, 64'd0);
    busRead(OFS_UPPER, d); check("R1 upper", {32'd0, d}, 64'd0);
    busRead(OFS_LOWER, d); check("R1 lower", {32'd0, d}, 64'd0);

    // R2 control layout, bit0 written 0
    busWrite(OFS_CTRL, 32'hFFFF_FFFE);
    busRead(OFS_CTRL, d); check("R2 ctrl readback", {32'd0, d}, 64'h7D00);

    // R12 unmapped address
    busWrite(8'h40, 32'hFFFF_FFFF);
    busRead(8'h40, d); check("R12 unmapped read", {32'd0, d}, 64'd0);
    busRead(OFS_CTRL, d); check("R12 ctrl untouched", {32'd0, d}, 64'h7D00);
    busWrite(OFS_CTRL, 32'd0);

    // R8 word-wise loads while stopped
    busWrite(OFS_UPPER, 32'd5); settle();
    busWrite(OFS_LOWER, 32'd7); settle();
    readCount(c0); check("R8 load both", c0, {32'd5, 32'd7});
    busWrite(OFS_LOWER, 32'd9); settle();
    readCount(c0); check("R8 upper kept", c0, {32'd5, 32'd9});

    // R7 write while running is ignored
    busWrite(OFS_CTRL, 32'd1); waitStatus(1'b1);
    readCount(c0);
    busWrite(OFS_LOWER, 32'h0000_0ABC); settle();
    busWrite(OFS_CTRL, 32'd0); waitStatus(1'b0);
    readCount(c1);
    check("R7 upper unchanged", {32'd0, c1[63:32]}, 64'd5);
    check("R7 lower kept counting",
          {63'd0, (c1[31:0] > c0[31:0]) && (c1[31:0] < c0[31:0] + 32'd64)}, 64'd1);

    // R11 stopped count holds
    repeat (5) @(posedge slowClk);
    #5 readCount(c0);
    check("R11 hold when stopped", c0, c1);

    // Vector table: R4, R5, R6, R9, R10
    for (int i = 0; i < 7; i++) begin
      busWrite(OFS_CTRL, 32'd0); waitStatus(1'b0);
      busWrite(OFS_UPPER, {16'd0, VEC[i].up}); settle();
      busWrite(OFS_LOWER, VEC[i].lo); settle();
      busWrite(OFS_CTRL, {17'd0, VEC[i].cal, 1'b0, VEC[i].calOn, 8'd1});
      waitStatus(1'b1);
      readCount(c0);
      check($sformatf("R4 start gap vec %0d", i), c0, {16'd0, VEC[i].up, VEC[i].lo});
      repeat (VEC[i].ticks) @(posedge slowClk);
      #5 readCount(c1);
      check($sformatf("R5/R6/R9/R10 vec %0d", i), c1, {16'd0, VEC[i].expUp, VEC[i].expLo});
    end
    busWrite(OFS_CTRL, 32'd0); waitStatus(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule